// File: doc/BRIEF.md
# Peripheral Interrupt Request and Vector Responder

This block sits between an I/O device and the maskable interrupt input of a processor. When the device signals that it is ready by pulling its ready line low, the block latches a request and raises the interrupt line. The processor answers with a sequence of two active-low acknowledge pulses. The block drops the request as soon as the first pulse is seen, so the processor does not take a still-high line as a new request. During the second pulse it places a fixed 8-bit type number on the low data bus lines. Outside that pulse the bus lines are released.

The data bus is shown as an output value plus an output-enable, and the pad logic outside the block forms the tri-state driver. All asynchronous inputs pass through a two-flop synchronizer and are edge-detected in the system clock domain. By default the second pulse is told apart from the first by the processor's lock signal: a pulse that begins while lock is already asserted is the second one. A parameter can select an internal pulse counter instead. A ready edge that arrives during an acknowledge sequence is not lost. It is held and raises the request again once the second pulse is over.

Top module: `irq_vector_responder`

## Requirements
- R1: A falling edge on `dev_rdy_n` sets `irq_req` high exactly 3 clock cycles after the input changes (two synchronizer stages plus the request register). A ready line that stays low does not retrigger the request after it has been cleared.
- R2: The first acknowledge pulse (`intack_n` falling) drives `irq_req` low 3 cycles after `intack_n` falls. `irq_req` stays low through the pulse and through the gap that follows.
- R3: While the synchronous active-high `rst` is asserted, `irq_req` and `vec_oe` are 0 and `vec_data` is 0 from the next clock edge on.
- R4: `vec_oe` rises 3 cycles after the second acknowledge pulse begins and falls 3 cycles after it ends. It stays 0 during the first pulse and during the gap.
- R5: `vec_data` equals the parameter `VECTOR` (default 8'h41) whenever `vec_oe` is 1, and is 0 whenever `vec_oe` is 0.
- R6: In lock mode (default, `QUAL` = QUAL_LOCK), an acknowledge pulse counts as the second pulse only when `lock_n` was already low in the cycle before `intack_n` fell. Two pulses that arrive without lock produce no vector drive.
- R7: A ready falling edge that arrives between the start of the first pulse and the end of the second pulse, including in the same cycle as the start of the first pulse, leaves `irq_req` low during the sequence. It then sets `irq_req` 3 cycles after `intack_n` rises at the end of the second pulse.
- R8: In counter mode (`QUAL` = QUAL_COUNT), every second acknowledge pulse after reset, or after the previous second pulse, is the second pulse and `lock_n` is ignored. The pulse count returns to 0 when a second pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dev_rdy_n | input | 1 | Device ready, asynchronous; a falling edge requests service |
| intack_n | input | 1 | Processor interrupt acknowledge strobe, asynchronous, active low |
| lock_n | input | 1 | Processor lock, asynchronous, active low; marks the second pulse in lock mode |
| irq_req | output | 1 | Interrupt request to the processor, active high, registered |
| vec_data | output | VEC_W | Type number for the low data bus lines, registered |
| vec_oe | output | 1 | Output-enable for the data bus drivers, registered |

## Verification
Two functions can fall in the same cycle: the request can be set by a ready edge and cleared by the start of the first acknowledge pulse. The bench provokes this by dropping `dev_rdy_n`, `intack_n` and `lock_n` on the same clock phase while a request is already high, so both edges reach the synchronized domain together. The outcome passes only if `irq_req` goes low 3 cycles later, stays low through the gap and the second pulse, and comes back high exactly 3 cycles after the second pulse is released. A lock-mode instance and a counter-mode instance run side by side on the same stimulus, so pulses without lock show the two qualifiers behaving differently.

// File: rtl/irqv_pkg.sv
`timescale 1ns/1ps
package irqv_pkg;

  // How the second acknowledge pulse is recognized
  typedef enum logic {
    QUAL_LOCK  = 1'b0,
    QUAL_COUNT = 1'b1
  } qual_mode_e;

  // Events decoded from the acknowledge strobe
  typedef struct packed {
    logic first_start;
    logic second_start;
    logic second_end;
    logic busy;
  } ack_ev_t;

endpackage

// File: rtl/irqv_sync.sv
`timescale 1ns/1ps
module irqv_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  localparam int LAST = STAGES - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[i]}};
      else     chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[LAST];
  end

endmodule

// File: rtl/irqv_ack_track.sv
`timescale 1ns/1ps
module irqv_ack_track
  import irqv_pkg::*;
#(
  parameter qual_mode_e QUAL  = QUAL_LOCK,
  parameter int         CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack_s,
  input  logic             lock_s,
  output ack_ev_t          ev,
  output logic [CNT_W-1:0] pulse_cnt,
  output logic             drive_next
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic ack_prev, lock_prev;
  logic ack_fall, ack_rise;
  logic is_second;
  logic in_second;
  logic busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_prev  <= 1'b1;
      lock_prev <= 1'b1;
    end else begin
      ack_prev  <= ack_s;
      lock_prev <= lock_s;
    end
  end

  assign ack_fall = ack_prev & ~ack_s;
  assign ack_rise = ~ack_prev & ack_s;

  // Second-pulse qualifier picked by parameter
  if (QUAL == QUAL_LOCK) begin : g_lock
    logic unused_cnt;
    assign unused_cnt = ^pulse_cnt;
    assign is_second  = ~lock_prev;
  end else begin : g_count
    logic unused_lock;
    assign unused_lock = lock_prev;
    assign is_second   = (pulse_cnt == CNT_ONE);
  end

  assign ev.first_start  = ack_fall & ~is_second;
  assign ev.second_start = ack_fall & is_second;
  assign ev.second_end   = ack_rise & in_second;
  assign ev.busy         = busy_q;

  assign drive_next = ev.second_start | (in_second & ~ack_rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_second <= 1'b0;
      busy_q    <= 1'b0;
      pulse_cnt <= '0;
    end else begin
      in_second <= drive_next;
      if (ev.second_end)       busy_q <= 1'b0;
      else if (ev.first_start) busy_q <= 1'b1;
      if (ev.second_end)
        pulse_cnt <= '0;
      else if (ev.first_start && pulse_cnt != CNT_MAX)
        pulse_cnt <= pulse_cnt + CNT_ONE;
    end
  end

endmodule

// File: rtl/irqv_req_latch.sv
`timescale 1ns/1ps
module irqv_req_latch
  import irqv_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    rdy_s,
  input  ack_ev_t ev,
  output logic    rdy_fall,
  output logic    irq
);

  logic rdy_prev;
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) rdy_prev <= 1'b1;
    else     rdy_prev <= rdy_s;
  end

  assign rdy_fall = rdy_prev & ~rdy_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq  <= 1'b0;
      pend <= 1'b0;
    end else if (ev.second_end) begin
      irq  <= pend | rdy_fall;
      pend <= 1'b0;
    end else if (ev.first_start) begin
      irq  <= 1'b0;
      pend <= pend | rdy_fall;
    end else if (ev.busy) begin
      if (rdy_fall) pend <= 1'b1;
    end else if (rdy_fall) begin
      irq <= 1'b1;
    end
  end

endmodule

// File: rtl/irq_vector_responder.sv
`timescale 1ns/1ps
module irq_vector_responder
  import irqv_pkg::*;
#(
  parameter int               VEC_W       = 8,
  parameter logic [VEC_W-1:0] VECTOR      = 8'h41,
  parameter qual_mode_e       QUAL        = QUAL_LOCK,
  parameter int               SYNC_STAGES = 2,
  parameter int               CNT_W       = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dev_rdy_n,
  input  logic             intack_n,
  input  logic             lock_n,
  output logic             irq_req,
  output logic [VEC_W-1:0] vec_data,
  output logic             vec_oe
);

  localparam int N_IN = 3;

  logic [N_IN-1:0]  raw_in, sync_in;
  ack_ev_t          ev;
  logic [CNT_W-1:0] pulse_cnt;
  logic             drive_next;
  logic             rdy_fall;
  logic             first_start, second_start, second_end;

  assign raw_in = {lock_n, intack_n, dev_rdy_n};

  irqv_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_in)
  );

  irqv_ack_track #(.QUAL(QUAL), .CNT_W(CNT_W)) u_ack (
    .clk(clk), .rst(rst), .ack_s(sync_in[1]), .lock_s(sync_in[2]),
    .ev(ev), .pulse_cnt(pulse_cnt), .drive_next(drive_next)
  );

  irqv_req_latch u_req (
    .clk(clk), .rst(rst), .rdy_s(sync_in[0]), .ev(ev),
    .rdy_fall(rdy_fall), .irq(irq_req)
  );

  assign first_start  = ev.first_start;
  assign second_start = ev.second_start;
  assign second_end   = ev.second_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_oe   <= 1'b0;
      vec_data <= '0;
    end else begin
      vec_oe   <= drive_next;
      vec_data <= drive_next ? VECTOR : '0;
    end
  end

endmodule

// File: rtl/irqv_checker.sv
`timescale 1ns/1ps
module irqv_checker #(
  parameter int               VEC_W  = 8,
  parameter logic [VEC_W-1:0] VECTOR = 8'h41,
  parameter int               CNT_W  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_req,
  input logic [VEC_W-1:0] vec_data,
  input logic             vec_oe,
  input logic             rdy_fall,
  input logic             first_start,
  input logic             second_start,
  input logic             second_end,
  input logic [CNT_W-1:0] pulse_cnt
);

  p_irq_cause_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(rdy_fall || second_end));

  p_first_clears_r2: assert property (@(posedge clk) disable iff (rst)
    first_start |=> !irq_req);

  p_oe_from_second_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_oe) |-> $past(second_start));

  p_vector_on_r5: assert property (@(posedge clk) disable iff (rst)
    vec_oe |-> (vec_data == VECTOR));

  p_bus_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !vec_oe |-> (vec_data == '0));

  p_cnt_clear_r8: assert property (@(posedge clk) disable iff (rst)
    second_end |=> (pulse_cnt == '0));

endmodule

bind irq_vector_responder irqv_checker #(
  .VEC_W(VEC_W), .VECTOR(VECTOR), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .irq_req(irq_req), .vec_data(vec_data),
  .vec_oe(vec_oe), .rdy_fall(rdy_fall), .first_start(first_start),
  .second_start(second_start), .second_end(second_end),
  .pulse_cnt(pulse_cnt)
);

// File: tb/irq_vector_responder_bench.sv
`timescale 1ns/1ps
module irq_vector_responder_bench;
  import irqv_pkg::*;

  localparam logic [7:0] VEC_A = 8'h41;
  localparam logic [7:0] VEC_B = 8'hA5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, rdy_n = 1'b1, ack_n = 1'b1, lock_n = 1'b1;
  logic irq_a, irq_b, oe_a, oe_b;
  logic [7:0] data_a, data_b;

  irq_vector_responder #(.VECTOR(VEC_A), .QUAL(QUAL_LOCK)) u_irq_vector_responder (
    .clk(clk), .rst(rst), .dev_rdy_n(rdy_n), .intack_n(ack_n), .lock_n(lock_n),
    .irq_req(irq_a), .vec_data(data_a), .vec_oe(oe_a)
  );

  irq_vector_responder #(.VECTOR(VEC_B), .QUAL(QUAL_COUNT)) u_irq_vector_responder_cnt (
    .clk(clk), .rst(rst), .dev_rdy_n(rdy_n), .intack_n(ack_n), .lock_n(lock_n),
    .irq_req(irq_b), .vec_data(data_b), .vec_oe(oe_b)
  );

  typedef struct {
    logic  irq;
    logic  oe_a;
    logic  oe_b;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic expect_now(logic irq, logic oea, logic oeb, string tag);
    exp_t e;
    e.irq = irq; e.oe_a = oea; e.oe_b = oeb; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Monitor: compares queued expectations against the outputs
  initial forever begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, "irq_a", int'(irq_a), int'(e.irq));
      check(e.tag, "irq_b", int'(irq_b), int'(e.irq));
      check(e.tag, "oe_a", int'(oe_a), int'(e.oe_a));
      check(e.tag, "oe_b", int'(oe_b), int'(e.oe_b));
      check(e.tag, "data_a", int'(data_a), e.oe_a ? int'(VEC_A) : 0);
      check(e.tag, "data_b", int'(data_b), e.oe_b ? int'(VEC_B) : 0);
    end
  end

  initial begin
    #1600000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(4);
    expect_now(0, 0, 0, "R3 reset state");
    rst = 1'b0;
    tick(4);

    // R1: ready edge, latency 3
    rdy_n = 1'b0;
    tick(2); expect_now(0, 0, 0, "R1 not yet");
    tick(1); expect_now(1, 0, 0, "R1 request set");
    tick(5); expect_now(1, 0, 0, "R1 request held");

    // Full locked sequence
    ack_n = 1'b0; lock_n = 1'b0;
    tick(3); expect_now(0, 0, 0, "R2 first pulse clears");
    tick(3); expect_now(0, 0, 0, "R1 low ready no retrigger");
    ack_n = 1'b1;
    tick(4); expect_now(0, 0, 0, "R4 gap no drive");
    ack_n = 1'b0;
    tick(2); expect_now(0, 0, 0, "R4 not yet");
    tick(1); expect_now(0, 1, 1, "R4 R5 R6 second pulse drive");
    ack_n = 1'b1; lock_n = 1'b1;
    tick(2); expect_now(0, 1, 1, "R4 drive held");
    tick(1); expect_now(0, 0, 0, "R4 drive released");
    rdy_n = 1'b1;
    tick(3);

    // R7: ready edge during gap is held
    rdy_n = 1'b0;
    tick(3); expect_now(1, 0, 0, "R1 set again");
    rdy_n = 1'b1;
    ack_n = 1'b0; lock_n = 1'b0;
    tick(3); expect_now(0, 0, 0, "R2 cleared");
    ack_n = 1'b1;
    tick(1);
    rdy_n = 1'b0;
    tick(4); expect_now(0, 0, 0, "R7 held during gap");
    ack_n = 1'b0;
    tick(3); expect_now(0, 1, 1, "R7 still low in pulse two");
    ack_n = 1'b1; lock_n = 1'b1;
    tick(2); expect_now(0, 1, 1, "R7 not yet");
    tick(1); expect_now(1, 0, 0, "R7 reasserted");

    // R7 collision: ready edge and first pulse in the same cycle
    rdy_n = 1'b1;
    tick(3);
    rdy_n = 1'b0; ack_n = 1'b0; lock_n = 1'b0;
    tick(3); expect_now(0, 0, 0, "R7 collision clear wins");
    ack_n = 1'b1;
    tick(3); expect_now(0, 0, 0, "R7 collision gap");
    ack_n = 1'b0;
    tick(3); expect_now(0, 1, 1, "R7 collision pulse two");
    ack_n = 1'b1; lock_n = 1'b1;
    tick(2); expect_now(0, 1, 1, "R7 collision not yet");
    tick(1); expect_now(1, 0, 0, "R7 collision reasserted");
    rdy_n = 1'b1;

    // R6/R8: pulses without lock
    tick(2);
    ack_n = 1'b0;
    tick(3); expect_now(0, 0, 0, "R8 pulse one no drive");
    ack_n = 1'b1;
    tick(3);
    ack_n = 1'b0;
    tick(3); expect_now(0, 0, 1, "R6 R8 pulse two without lock");
    ack_n = 1'b1;
    tick(3); expect_now(0, 0, 0, "R8 released");
    ack_n = 1'b0;
    tick(3); expect_now(0, 0, 0, "R8 count restarted");
    ack_n = 1'b1;
    tick(3);
    ack_n = 1'b0;
    tick(3); expect_now(0, 0, 1, "R6 R8 fourth pulse");
    ack_n = 1'b1;
    tick(3); expect_now(0, 0, 0, "R8 released again");

    // R3: reset mid-operation
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    tick(3);
    rdy_n = 1'b0;
    tick(3); expect_now(1, 0, 0, "R1 after reset");
    rst = 1'b1;
    tick(1); expect_now(0, 0, 0, "R3 reset clears request");
    rst = 1'b0;
    tick(3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule